// File: doc/BRIEF.md
# VMEbus Master Access Router

This block sits between an embedded controller and a VMEbus-style master port. Each access request carries an address, an address-space select (A24 or A16), a read/write flag, a tag saying whether it is a command fetch or a data transfer, and write data. For every request the router picks the address modifier and the data width. It also decides whether an A24 address is served from a local slave-memory window rather than by a bus cycle. It then runs exactly one transaction, either on the bus or on the local port, and returns a one-cycle done pulse with an error flag and read data.

The slave window is described by a base register, a size register and an enable bit. Only the start address of a request is compared against it. An item that begins inside the window and runs past its end is not split or flagged. Command fetches choose their width from the address alignment. Data transfers follow a configuration bit, which lets software reach 8-bit peripherals with D08(EO) cycles.

The controller is a six-state machine:
- `ST_IDLE` accepts a request.
- `ST_IDLE→ST_LOC_ACC→ST_LOC_DONE→ST_IDLE` serves a window hit.
- `ST_IDLE→ST_BUS_CYC→ST_BUS_DONE→ST_IDLE` runs a bus cycle. The machine leaves `ST_BUS_CYC` on acknowledge, bus error or timeout.
- `ST_IDLE→ST_FAULT→ST_IDLE` rejects a misaligned D16 data request.

Bus strobes, address strobe, acknowledge and bus error are active high on this port.

Top module: `vme_master_router`

## Requirements
- R1: A bus access in A24 space (req_a16=0) drives address modifier 0x3D and the full 24-bit request address on vme_addr.
- R2: A bus access in A16 space (req_a16=1) drives address modifier 0x2D, places req_addr[15:0] on vme_addr with bits 23:16 zero, and is never served locally.
- R3: When cfg_win_en=1 and an A24 address satisfies base <= addr < base+size, the access raises loc_en for exactly one cycle with the request address, write flag and write data, and no bus cycle (vme_as) occurs. Local read data is taken from loc_rdata in the cycle after loc_en.
- R4: The window decision uses the start address alone. base+size-1 and base+size-2 are served locally. base+size and base-1 go to the bus.
- R5: Command fetches (req_is_cmd=1) ignore cfg_data_d8. An even address uses D16, with both vme_ds0 and vme_ds1 high. An odd address uses D08(EO), with only vme_ds0 high.
- R6: For data transfers with cfg_data_d8=1, the access is D08(EO): an odd address raises only vme_ds0 and an even address raises only vme_ds1. With cfg_data_d8=0 the access is D16, with both strobes high.
- R7: A data transfer with cfg_data_d8=0 and an odd address completes with rsp_err=1 after one cycle and produces neither a bus nor a local cycle, even inside the window.
- R8: A bus cycle ends when vme_dtack or vme_berr is sampled high. vme_berr gives rsp_err=1 and takes priority over a simultaneous vme_dtack. A read ended by acknowledge returns vme_rdata in rsp_rdata. rsp_rdata is zero for writes and errors.
- R9: If neither acknowledge nor bus error arrives, the bus cycle ends after TIMEOUT_CYC (256) cycles of vme_as with rsp_err=1.
- R10: rsp_done is a one-cycle pulse, given once per accepted request. req_ready is high only while the block is idle.
- R11: While reset is asserted, every output is zero except req_ready, which is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when req_ready is high |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 24 | Request byte address |
| req_a16 | input | 1 | 1 = A16 space, 0 = A24 space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_is_cmd | input | 1 | 1 = command fetch, 0 = data transfer |
| req_wdata | input | 16 | Write data |
| cfg_win_en | input | 1 | Slave window enable |
| cfg_win_base | input | 24 | Slave window base address |
| cfg_win_size | input | 24 | Slave window size in bytes |
| cfg_data_d8 | input | 1 | 1 = data transfers use D08(EO), 0 = D16 |
| vme_as | output | 1 | Address strobe, high for the whole bus cycle |
| vme_am | output | 6 | Address modifier |
| vme_addr | output | 24 | Bus address |
| vme_ds0 | output | 1 | Data strobe for the odd byte |
| vme_ds1 | output | 1 | Data strobe for the even byte |
| vme_write | output | 1 | Bus write |
| vme_wdata | output | 16 | Bus write data |
| vme_rdata | input | 16 | Bus read data |
| vme_dtack | input | 1 | Bus acknowledge |
| vme_berr | input | 1 | Bus error |
| loc_en | output | 1 | Local memory access strobe |
| loc_write | output | 1 | Local memory write |
| loc_addr | output | 24 | Local memory address |
| loc_wdata | output | 16 | Local memory write data |
| loc_rdata | input | 16 | Local memory read data, valid the cycle after loc_en |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion with error |
| rsp_rdata | output | 16 | Read data returned with rsp_done |

## Verification
Several properties are checked on every cycle:
- A local access never overlaps a bus cycle, and loc_en lasts one cycle and is followed by the done pulse.
- An A16 modifier never appears with a non-zero upper address, and any active bus cycle carries at least one data strobe.
- The done pulse is single and never appears while the block reports ready.
- The address strobe is never held longer than the timeout.

Other behaviours depend on which request and configuration were applied, so only the bench's scenarios can show them: the exact window boundaries, strobe selection for each width and alignment, command fetches overriding the data-width bit, bus-error priority, the 256-cycle timeout and the returned read data.

// File: rtl/vmr_pkg.sv
package vmr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOC_ACC,
        ST_LOC_DONE,
        ST_BUS_CYC,
        ST_BUS_DONE,
        ST_FAULT
    } vmr_state_e;

    localparam logic [5:0] AM_A24_SUP_DATA = 6'h3D;
    localparam logic [5:0] AM_A16_SUP      = 6'h2D;

    typedef struct packed {
        logic       local_hit;
        logic       misalign;
        logic [5:0] am;
        logic       ds0;
        logic       ds1;
    } vmr_route_t;

endpackage

// File: rtl/vmr_decode.sv
module vmr_decode
    import vmr_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              a16,
    input  logic              is_cmd,
    input  logic              win_en,
    input  logic [ADDR_W-1:0] win_base,
    input  logic [ADDR_W-1:0] win_size,
    input  logic              data_d8,
    output vmr_route_t        route
);

    logic [ADDR_W:0] addr_x;
    logic [ADDR_W:0] lo_x;
    logic [ADDR_W:0] hi_x;
    logic            in_win;
    logic            byte_mode;

    always_comb begin
        addr_x    = {1'b0, addr};
        lo_x      = {1'b0, win_base};
        hi_x      = lo_x + {1'b0, win_size};
        // start address only: no length enters the comparison
        in_win    = (addr_x >= lo_x) && (addr_x < hi_x);
        byte_mode = is_cmd ? addr[0] : data_d8;

        route.local_hit = win_en && !a16 && in_win;
        route.misalign  = !is_cmd && !data_d8 && addr[0];
        route.am        = a16 ? AM_A16_SUP : AM_A24_SUP_DATA;
        route.ds0       = !byte_mode || addr[0];
        route.ds1       = !byte_mode || !addr[0];
    end

endmodule

// File: rtl/vmr_timeout.sv
module vmr_timeout #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic expired
);

    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_q;

    assign expired = active && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/vme_master_router.sv
module vme_master_router
    import vmr_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int A16_W       = 16,
    parameter int DATA_W      = 16,
    parameter int TIMEOUT_CYC = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_a16,
    input  logic              req_write,
    input  logic              req_is_cmd,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_win_en,
    input  logic [ADDR_W-1:0] cfg_win_base,
    input  logic [ADDR_W-1:0] cfg_win_size,
    input  logic              cfg_data_d8,
    output logic              vme_as,
    output logic [5:0]        vme_am,
    output logic [ADDR_W-1:0] vme_addr,
    output logic              vme_ds0,
    output logic              vme_ds1,
    output logic              vme_write,
    output logic [DATA_W-1:0] vme_wdata,
    input  logic [DATA_W-1:0] vme_rdata,
    input  logic              vme_dtack,
    input  logic              vme_berr,
    output logic              loc_en,
    output logic              loc_write,
    output logic [ADDR_W-1:0] loc_addr,
    output logic [DATA_W-1:0] loc_wdata,
    input  logic [DATA_W-1:0] loc_rdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);

    vmr_state_e        state_q, state_d;
    vmr_route_t        route;
    logic              tmo_expired;
    logic              accept;
    logic [ADDR_W-1:0] laddr_q;
    logic [ADDR_W-1:0] baddr_q;
    logic [5:0]        am_q;
    logic              ds0_q, ds1_q;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;

    vmr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr     (req_addr),
        .a16      (req_a16),
        .is_cmd   (req_is_cmd),
        .win_en   (cfg_win_en),
        .win_base (cfg_win_base),
        .win_size (cfg_win_size),
        .data_d8  (cfg_data_d8),
        .route    (route)
    );

    vmr_timeout #(.LIMIT(TIMEOUT_CYC)) u_timeout (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (state_q == ST_BUS_CYC),
        .expired (tmo_expired)
    );

    assign accept = (state_q == ST_IDLE) && req_valid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (route.misalign)       state_d = ST_FAULT;
                    else if (route.local_hit) state_d = ST_LOC_ACC;
                    else                      state_d = ST_BUS_CYC;
                end
            end
            ST_LOC_ACC:  state_d = ST_LOC_DONE;
            ST_LOC_DONE: state_d = ST_IDLE;
            ST_BUS_CYC: begin
                if (vme_berr || vme_dtack || tmo_expired) state_d = ST_BUS_DONE;
            end
            ST_BUS_DONE: state_d = ST_IDLE;
            ST_FAULT:    state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // request latch and bus result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            laddr_q <= '0;
            baddr_q <= '0;
            am_q    <= '0;
            ds0_q   <= 1'b0;
            ds1_q   <= 1'b0;
            write_q <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (accept) begin
                laddr_q <= req_addr;
                baddr_q <= req_a16 ? ADDR_W'(req_addr[A16_W-1:0]) : req_addr;
                am_q    <= route.am;
                ds0_q   <= route.ds0;
                ds1_q   <= route.ds1;
                write_q <= req_write;
                wdata_q <= req_wdata;
            end
            if (state_q == ST_BUS_CYC) begin
                if (vme_berr) begin
                    err_q <= 1'b1;
                end else if (vme_dtack) begin
                    err_q   <= 1'b0;
                    rdata_q <= vme_rdata;
                end else if (tmo_expired) begin
                    err_q <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        vme_as    = 1'b0;
        vme_am    = '0;
        vme_addr  = '0;
        vme_ds0   = 1'b0;
        vme_ds1   = 1'b0;
        vme_write = 1'b0;
        vme_wdata = '0;
        loc_en    = 1'b0;
        loc_write = 1'b0;
        loc_addr  = '0;
        loc_wdata = '0;
        rsp_done  = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_LOC_ACC: begin
                loc_en    = 1'b1;
                loc_write = write_q;
                loc_addr  = laddr_q;
                loc_wdata = wdata_q;
            end
            ST_LOC_DONE: begin
                rsp_done  = 1'b1;
                rsp_rdata = write_q ? '0 : loc_rdata;
            end
            ST_BUS_CYC: begin
                vme_as    = 1'b1;
                vme_am    = am_q;
                vme_addr  = baddr_q;
                vme_ds0   = ds0_q;
                vme_ds1   = ds1_q;
                vme_write = write_q;
                vme_wdata = wdata_q;
            end
            ST_BUS_DONE: begin
                rsp_done  = 1'b1;
                rsp_err   = err_q;
                rsp_rdata = (err_q || write_q) ? '0 : rdata_q;
            end
            ST_FAULT: begin
                rsp_done = 1'b1;
                rsp_err  = 1'b1;
            end
            default: req_ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/vmr_checker.sv
module vmr_checker #(
    parameter int ADDR_W      = 24,
    parameter int TIMEOUT_CYC = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              vme_as,
    input logic [5:0]        vme_am,
    input logic [ADDR_W-1:0] vme_addr,
    input logic              vme_ds0,
    input logic              vme_ds1,
    input logic              loc_en,
    input logic              rsp_done
);

    localparam int RW = $clog2(TIMEOUT_CYC + 2) + 1;

    logic [RW-1:0] as_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       as_run_q <= '0;
        else if (!vme_as) as_run_q <= '0;
        else              as_run_q <= as_run_q + 1'b1;
    end

    AST_A16_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (vme_as && vme_am == 6'h2D) |-> (vme_addr[ADDR_W-1:16] == '0)); // R2

    AST_LOCAL_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        loc_en |-> !vme_as); // R3

    AST_LOCAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        loc_en |=> (!loc_en && rsp_done)); // R3

    AST_STROBE_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        vme_as |-> (vme_ds0 || vme_ds1)); // R6

    AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !vme_as |-> (!vme_ds0 && !vme_ds1)); // R6

    AST_BUS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        vme_as |-> (as_run_q < RW'(TIMEOUT_CYC))); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R10

    AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !req_ready); // R10

endmodule

bind vme_master_router vmr_checker #(
    .ADDR_W      (ADDR_W),
    .TIMEOUT_CYC (TIMEOUT_CYC)
) u_vmr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .vme_as    (vme_as),
    .vme_am    (vme_am),
    .vme_addr  (vme_addr),
    .vme_ds0   (vme_ds0),
    .vme_ds1   (vme_ds1),
    .loc_en    (loc_en),
    .rsp_done  (rsp_done)
);

// File: tb/tb_vme_master_router.sv
module tb_vme_master_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic        req_a16 = 1'b0;
    logic        req_write = 1'b0;
    logic        req_is_cmd = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        cfg_win_en = 1'b0;
    logic [23:0] cfg_win_base = 24'h40_0000;
    logic [23:0] cfg_win_size = 24'h00_1000;
    logic        cfg_data_d8 = 1'b0;
    logic        vme_as;
    logic [5:0]  vme_am;
    logic [23:0] vme_addr;
    logic        vme_ds0, vme_ds1, vme_write;
    logic [15:0] vme_wdata;
    logic [15:0] vme_rdata;
    logic        vme_dtack = 1'b0;
    logic        vme_berr = 1'b0;
    logic        loc_en, loc_write;
    logic [23:0] loc_addr;
    logic [15:0] loc_wdata;
    logic [15:0] loc_rdata = '0;
    logic        rsp_done, rsp_err;
    logic [15:0] rsp_rdata;

    int    n_checks = 0;
    int    n_errors = 0;
    string scen = "R11";
    bit    run_cmp = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    vme_master_router dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_a16(req_a16), .req_write(req_write), .req_is_cmd(req_is_cmd),
        .req_wdata(req_wdata),
        .cfg_win_en(cfg_win_en), .cfg_win_base(cfg_win_base),
        .cfg_win_size(cfg_win_size), .cfg_data_d8(cfg_data_d8),
        .vme_as(vme_as), .vme_am(vme_am), .vme_addr(vme_addr),
        .vme_ds0(vme_ds0), .vme_ds1(vme_ds1), .vme_write(vme_write),
        .vme_wdata(vme_wdata), .vme_rdata(vme_rdata),
        .vme_dtack(vme_dtack), .vme_berr(vme_berr),
        .loc_en(loc_en), .loc_write(loc_write), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s (scenario %s) at %0t: actual=%h expected=%h", tag, scen, $time, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // ---- peripherals: local memory and bus responder ----
    always @(posedge clk) begin
        if (loc_en && !loc_write) loc_rdata <= loc_addr[15:0] ^ 16'hA5A5;
    end

    assign vme_rdata = vme_addr[15:0] ^ 16'h5A5A;

    int resp_mode = 0;  // 0 dtack, 1 berr, 2 silent, 3 dtack+berr
    int resp_dly  = 1;
    int bus_cnt   = 0;
    always @(negedge clk) begin
        if (vme_as) begin
            bus_cnt++;
            vme_dtack <= (bus_cnt == resp_dly) && (resp_mode == 0 || resp_mode == 3);
            vme_berr  <= (bus_cnt == resp_dly) && (resp_mode == 1 || resp_mode == 3);
        end else begin
            bus_cnt = 0;
            vme_dtack <= 1'b0;
            vme_berr  <= 1'b0;
        end
    end

    // ---- behavioural reference ----
    // ph: 0 waiting, 1 local strobe, 2 local reply, 3 on bus, 4 bus reply, 5 rejected
    int          ph = 0;
    int          waited = 0;
    logic [23:0] m_addr, m_baddr;
    logic [15:0] m_wd;
    bit          m_w, m_a16, m_err, m_ds0, m_ds1;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0;
        end else begin
            case (ph)
                0: if (req_valid) begin
                    bit narrow, odd, hit, bad;
                    int a, b, s;
                    a = int'(req_addr); b = int'(cfg_win_base); s = int'(cfg_win_size);
                    odd    = req_addr[0];
                    narrow = req_is_cmd ? odd : cfg_data_d8;
                    bad    = !req_is_cmd && !cfg_data_d8 && odd;
                    hit    = cfg_win_en && !req_a16 && (a >= b) && (a < b + s);
                    m_addr  = req_addr;
                    m_baddr = req_a16 ? {8'h00, req_addr[15:0]} : req_addr;
                    m_wd = req_wdata; m_w = req_write; m_a16 = req_a16;
                    m_ds0 = !narrow || odd;
                    m_ds1 = !narrow || !odd;
                    waited = 0;
                    ph = bad ? 5 : (hit ? 1 : 3);
                end
                1: ph = 2;
                3: begin
                    if (vme_berr)        begin m_err = 1; ph = 4; end
                    else if (vme_dtack)  begin m_err = 0; ph = 4; end
                    else if (waited == 255) begin m_err = 1; ph = 4; end
                    else waited++;
                end
                default: ph = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (run_cmp && rst_n) begin
            logic [15:0] erd;
            erd = 16'h0;
            if (ph == 2 && !m_w) erd = m_addr[15:0] ^ 16'hA5A5;
            if (ph == 4 && !m_w && !m_err) erd = m_baddr[15:0] ^ 16'h5A5A;
            chk("R10 ready", 32'(req_ready), 32'(ph == 0));
            chk("R10 done",  32'(rsp_done), 32'(ph == 2 || ph == 4 || ph == 5));
            chk("R8 err",    32'(rsp_err), 32'((ph == 4 && m_err) || ph == 5));
            chk("R8 rdata",  32'(rsp_rdata), 32'(erd));
            chk("R3 loc_en", 32'(loc_en), 32'(ph == 1));
            chk("R3 loc_fields", {loc_write, loc_addr, 7'h0},
                (ph == 1) ? {m_w, m_addr, 7'h0} : 32'h0);
            chk("R3 loc_wdata", 32'(loc_wdata), (ph == 1) ? 32'(m_wd) : 32'h0);
            chk("R3 vme_as", 32'(vme_as), 32'(ph == 3));
            chk("R1 am", 32'(vme_am), (ph == 3) ? (m_a16 ? 32'h2D : 32'h3D) : 32'h0);
            chk("R1 addr", 32'(vme_addr), (ph == 3) ? 32'(m_baddr) : 32'h0);
            chk("R6 strobes", {30'h0, vme_ds0, vme_ds1},
                (ph == 3) ? {30'h0, m_ds0, m_ds1} : 32'h0);
            chk("R8 write", {vme_write, 15'h0, vme_wdata},
                (ph == 3) ? {m_w, 15'h0, m_wd} : 32'h0);
        end
    end

    // ---- watchdog ----
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    task automatic do_req(input string tag, input logic [23:0] a, input bit a16,
                          input bit w, input bit cmd, input logic [15:0] wd);
        scen = tag;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_addr = a; req_a16 = a16; req_write = w; req_is_cmd = cmd; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_done) @(negedge clk);
    endtask

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        chk("R11 ready", 32'(req_ready), 32'h1);
        chk("R11 quiet", {vme_as, vme_ds0, vme_ds1, vme_write, loc_en, loc_write, rsp_done, rsp_err},
            32'h0);
        chk("R11 buses", 32'(vme_am) | 32'(vme_addr) | 32'(loc_addr) | 32'(rsp_rdata), 32'h0);
        rst_n = 1'b1;
        run_cmp = 1'b1;

        // R1: A24 data reads and writes on the bus, D16
        resp_mode = 0; resp_dly = 2;
        do_req("R1", 24'h12_3456, 0, 0, 0, 16'h0);
        do_req("R1", 24'h12_3458, 0, 1, 0, 16'hBEEF);
        // R3: window disabled, address that would hit goes to the bus
        do_req("R3", 24'h40_0010, 0, 0, 0, 16'h0);
        // R2: A16 read, upper bits dropped
        resp_dly = 1;
        do_req("R2", 24'hAB_1234, 1, 0, 0, 16'h0);

        @(negedge clk); cfg_win_en = 1'b1;
        // R3: local read and write inside window
        do_req("R3", 24'h40_0010, 0, 0, 0, 16'h0);
        do_req("R3", 24'h40_0020, 0, 1, 0, 16'h1357);
        // R2: A16 address inside window range is never local
        do_req("R2", 24'h40_0010, 1, 0, 0, 16'h0);
        // R4: boundaries, start address only
        do_req("R4", 24'h40_0FFF, 0, 0, 1, 16'h0);
        do_req("R4", 24'h40_0FFE, 0, 0, 0, 16'h0);
        do_req("R4", 24'h40_1000, 0, 0, 0, 16'h0);
        do_req("R4", 24'h3F_FFFE, 0, 0, 0, 16'h0);

        // R5: command fetches ignore the data-width bit
        @(negedge clk); cfg_data_d8 = 1'b0;
        do_req("R5", 24'h12_3457, 0, 0, 1, 16'h0);
        @(negedge clk); cfg_data_d8 = 1'b1;
        do_req("R5", 24'h12_3458, 0, 0, 1, 16'h0);
        // R6: D08(EO) data strobes
        do_req("R6", 24'h20_0001, 0, 0, 0, 16'h0);
        do_req("R6", 24'h20_0002, 0, 1, 0, 16'h00A5);
        do_req("R6", 24'h00_0033, 1, 0, 0, 16'h0);

        // R7: misaligned D16 data, on the bus and inside the window
        @(negedge clk); cfg_data_d8 = 1'b0;
        do_req("R7", 24'h20_0003, 0, 0, 0, 16'h0);
        do_req("R7", 24'h40_0011, 0, 1, 0, 16'h7777);

        // R8: bus error, and bus error together with acknowledge
        resp_mode = 1; resp_dly = 3;
        do_req("R8", 24'h30_0000, 0, 0, 0, 16'h0);
        resp_mode = 3; resp_dly = 1;
        do_req("R8", 24'h30_0004, 0, 1, 0, 16'h4242);
        // R9: silent bus times out
        resp_mode = 2;
        do_req("R9", 24'h30_0008, 0, 0, 0, 16'h0);
        // recovery after timeout (R10)
        resp_mode = 0; resp_dly = 4;
        do_req("R10", 24'h30_000A, 0, 0, 0, 16'h0);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule